// File: doc/BRIEF.md
# Compute Unit Source Operand Collector

This block sits in front of one compute unit that takes six source operands. When an operation is issued, it works out which operand slots must be fetched from register file ports and raises a read request for each of them. It captures the data that comes back with each port grant. When every outstanding operand has arrived, it offers the full operand set to the pipeline through a valid/ready handshake.

Two slots can be filled locally instead of from a register file. If the operation's zero flag is set, slot 0 is forced to all zeros. If its immediate-valid flag is set, slot 1 takes the immediate value carried with the operation. No read request is raised for an overridden slot. Slots the operation does not need are neither requested nor loaded, and they present zero. The collector handles one operation at a time and accepts a new one only when idle.

Top module: `src_gather`

## Requirements
- R1: `issue_ready` is high exactly when no operation is in progress. An issue attempt while busy is ignored: it changes neither the requests nor the operands.
- R2: In the cycle after an accepted issue, `rd_req[i]` is high for each slot i whose `issue_need[i]` bit is 1 and that is not overridden. No request is raised for an unneeded slot.
- R3: With `issue_zero` set, slot 0 presents all zeros and `rd_req[0]` stays low for the whole operation.
- R4: With `issue_imm_ok` set, slot 1 presents `issue_imm` and `rd_req[1]` stays low for the whole operation.
- R5: The zero override acts on slot 0 only, and the immediate override acts on slot 1 only. Every other needed slot is requested and loaded as usual.
- R6: A raised `rd_req[i]` stays high until `rd_grant[i]` is high at a clock edge. `rd_data<i>` is captured at that same edge, and the request drops in the next cycle.
- R7: `out_valid` rises in the cycle after the grant of the last outstanding slot. It rises in the cycle after issue if no slot needs a read. It is never high while any request is pending.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and every operand output hold steady. A clock edge with both high ends the operation, and in the next cycle `out_valid` is low and `issue_ready` is high.
- R9: The slot widths are 64, 64, 32, 4, 4 and 4 bits for slots 0 to 5. A slot that is neither needed nor overridden presents zero.
- R10: A grant on a slot with no pending request is ignored, and that slot keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An operation is offered |
| issue_ready | output | 1 | Collector is idle and can accept an operation |
| issue_need | input | 6 | Per-slot needed bits, bit i for slot i |
| issue_zero | input | 1 | Force slot 0 to zero |
| issue_imm_ok | input | 1 | Immediate is valid and replaces slot 1 |
| issue_imm | input | 64 | Immediate value |
| rd_req | output | 6 | Per-slot read request, bit i for slot i |
| rd_grant | input | 6 | Per-slot port grant, bit i for slot i |
| rd_data0 | input | 64 | Read data for slot 0 |
| rd_data1 | input | 64 | Read data for slot 1 |
| rd_data2 | input | 32 | Read data for slot 2 |
| rd_data3 | input | 4 | Read data for slot 3 |
| rd_data4 | input | 4 | Read data for slot 4 |
| rd_data5 | input | 4 | Read data for slot 5 |
| out_valid | output | 1 | Operand set is complete |
| out_ready | input | 1 | Pipeline accepts the operand set |
| out_op0 | output | 64 | Slot 0 operand |
| out_op1 | output | 64 | Slot 1 operand |
| out_op2 | output | 32 | Slot 2 operand |
| out_op3 | output | 4 | Slot 3 operand |
| out_op4 | output | 4 | Slot 4 operand |
| out_op5 | output | 4 | Slot 5 operand |

## Verification
Requests come from a register, so they are due one cycle after the issue edge. They fall one cycle after the granting edge. `out_valid` comes from the pending state alone, so it is due one cycle after the last grant edge, or one cycle after issue when nothing is outstanding. The bench drives every input on the falling clock edge and samples on the next falling edge. This puts exactly one rising edge between a stimulus and its check. The bench also checks the cycle before each due point to confirm that nothing arrives early.

// File: rtl/gather_pkg.sv
package gather_pkg;
  localparam int unsigned NSLOT = 6;

  // Slots that need a register-file read: needed and not locally overridden.
  function automatic logic [NSLOT-1:0] fetch_mask(input logic [NSLOT-1:0] need,
                                                  input logic zero_f,
                                                  input logic imm_f);
    logic [NSLOT-1:0] m;
    m = need;
    if (zero_f) m[0] = 1'b0;
    if (imm_f)  m[1] = 1'b0;
    return m;
  endfunction

  // Value a slot is loaded with at issue time.
  function automatic logic [63:0] seed_value(input int unsigned slot,
                                             input logic imm_f,
                                             input logic [63:0] imm);
    return (slot == 1 && imm_f) ? imm : 64'd0;
  endfunction
endpackage

// File: rtl/gather_ctrl.sv
module gather_ctrl
  import gather_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_fire,
  input  logic [NSLOT-1:0] issue_need,
  input  logic             issue_zero,
  input  logic             issue_imm_ok,
  input  logic [NSLOT-1:0] rd_grant,
  input  logic             out_fire,
  output logic             busy,
  output logic             zero_q,
  output logic             imm_q,
  output logic [NSLOT-1:0] pend,
  output logic [NSLOT-1:0] take
);
  assign take = pend & rd_grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      zero_q <= 1'b0;
      imm_q  <= 1'b0;
      pend   <= '0;
    end else if (issue_fire) begin
      busy   <= 1'b1;
      zero_q <= issue_zero;
      imm_q  <= issue_imm_ok;
      pend   <= fetch_mask(issue_need, issue_zero, issue_imm_ok);
    end else begin
      pend <= pend & ~take;
      if (out_fire) begin
        busy   <= 1'b0;
        zero_q <= 1'b0;
        imm_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gather_slot.sv
module gather_slot #(
  parameter int unsigned W    = 64,
  parameter int unsigned MAXW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_seed,
  input  logic [MAXW-1:0] seed,
  input  logic            take,
  input  logic [MAXW-1:0] din,
  output logic [MAXW-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)         q <= '0;
    else if (load_seed) q <= seed[W-1:0];
    else if (take)      q <= din[W-1:0];
  end

  assign q_o = MAXW'(q);
endmodule

// File: rtl/src_gather.sv
module src_gather
  import gather_pkg::*;
#(
  parameter int unsigned W0 = 64,
  parameter int unsigned W1 = 64,
  parameter int unsigned W2 = 32,
  parameter int unsigned W3 = 4,
  parameter int unsigned W4 = 4,
  parameter int unsigned W5 = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  output logic          issue_ready,
  input  logic [5:0]    issue_need,
  input  logic          issue_zero,
  input  logic          issue_imm_ok,
  input  logic [W1-1:0] issue_imm,
  output logic [5:0]    rd_req,
  input  logic [5:0]    rd_grant,
  input  logic [W0-1:0] rd_data0,
  input  logic [W1-1:0] rd_data1,
  input  logic [W2-1:0] rd_data2,
  input  logic [W3-1:0] rd_data3,
  input  logic [W4-1:0] rd_data4,
  input  logic [W5-1:0] rd_data5,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W0-1:0] out_op0,
  output logic [W1-1:0] out_op1,
  output logic [W2-1:0] out_op2,
  output logic [W3-1:0] out_op3,
  output logic [W4-1:0] out_op4,
  output logic [W5-1:0] out_op5
);
  localparam int unsigned MAXW = 64;
  localparam int unsigned SW [NSLOT] = '{W0, W1, W2, W3, W4, W5};

  // Named internal events, also used by the checker.
  logic             busy, zero_q, imm_q;
  logic             issue_fire, out_fire;
  logic [NSLOT-1:0] pend, take;
  logic [MAXW-1:0]  din_arr [NSLOT];
  logic [MAXW-1:0]  q_arr   [NSLOT];

  assign issue_ready = !busy;
  assign issue_fire  = issue_valid && issue_ready;
  assign out_valid   = busy && (pend == '0);
  assign out_fire    = out_valid && out_ready;
  assign rd_req      = pend;

  assign din_arr[0] = MAXW'(rd_data0);
  assign din_arr[1] = MAXW'(rd_data1);
  assign din_arr[2] = MAXW'(rd_data2);
  assign din_arr[3] = MAXW'(rd_data3);
  assign din_arr[4] = MAXW'(rd_data4);
  assign din_arr[5] = MAXW'(rd_data5);

  gather_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_fire   (issue_fire),
    .issue_need   (issue_need),
    .issue_zero   (issue_zero),
    .issue_imm_ok (issue_imm_ok),
    .rd_grant     (rd_grant),
    .out_fire     (out_fire),
    .busy         (busy),
    .zero_q       (zero_q),
    .imm_q        (imm_q),
    .pend         (pend),
    .take         (take)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [MAXW-1:0] seed;
    assign seed = seed_value(g, issue_imm_ok, MAXW'(issue_imm));
    gather_slot #(.W(SW[g]), .MAXW(MAXW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_seed (issue_fire),
      .seed      (seed),
      .take      (take[g]),
      .din       (din_arr[g]),
      .q_o       (q_arr[g])
    );
  end

  assign out_op0 = q_arr[0][W0-1:0];
  assign out_op1 = q_arr[1][W1-1:0];
  assign out_op2 = q_arr[2][W2-1:0];
  assign out_op3 = q_arr[3][W3-1:0];
  assign out_op4 = q_arr[4][W4-1:0];
  assign out_op5 = q_arr[5][W5-1:0];
endmodule

// File: rtl/gather_chk.sv
module gather_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        zero_q,
  input logic        imm_q,
  input logic        issue_ready,
  input logic [5:0]  rd_req,
  input logic [5:0]  rd_grant,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_op0
);
  // R1
  idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !issue_ready);
  // R3
  zero_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && zero_q) |-> !rd_req[0]);
  // R3
  zero_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && zero_q) |-> (out_op0 == 64'd0));
  // R4
  imm_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && imm_q) |-> !rd_req[1]);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rd_req & ~rd_grant)) |=> ((rd_req & $past(rd_req & ~rd_grant)) == $past(rd_req & ~rd_grant)));
  // R7
  valid_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rd_req == 6'd0));
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op0)));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && issue_ready));
endmodule

bind src_gather gather_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .zero_q      (zero_q),
  .imm_q       (imm_q),
  .issue_ready (issue_ready),
  .rd_req      (rd_req),
  .rd_grant    (rd_grant),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_op0     (q_arr[0])
);

// File: tb/src_gather_tb.sv
module src_gather_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic issue_ready;
  logic [5:0] issue_need = '0;
  logic issue_zero = 1'b0;
  logic issue_imm_ok = 1'b0;
  logic [63:0] issue_imm = '0;
  logic [5:0] rd_req;
  logic [5:0] rd_grant = '0;
  logic [63:0] rd_data0 = '0;
  logic [63:0] rd_data1 = '0;
  logic [31:0] rd_data2 = '0;
  logic [3:0] rd_data3 = '0;
  logic [3:0] rd_data4 = '0;
  logic [3:0] rd_data5 = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [63:0] out_op0, out_op1;
  logic [31:0] out_op2;
  logic [3:0] out_op3, out_op4, out_op5;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_op [6];

  always #2.5 clk = ~clk;

  src_gather u_dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] out_of(input int i);
    case (i)
      0: return out_op0;
      1: return out_op1;
      2: return {32'd0, out_op2};
      3: return {60'd0, out_op3};
      4: return {60'd0, out_op4};
      default: return {60'd0, out_op5};
    endcase
  endfunction

  function automatic logic [63:0] wmask(input int i);
    case (i)
      0, 1: return {64{1'b1}};
      2: return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hF;
    endcase
  endfunction

  task automatic chk_ops(input string tag);
    for (int i = 0; i < 6; i++) chk(tag, out_of(i), exp_op[i]);
  endtask

  task automatic issue(input logic [5:0] need, input logic z, input logic im, input logic [63:0] imm);
    @(negedge clk);
    issue_valid = 1'b1; issue_need = need; issue_zero = z; issue_imm_ok = im; issue_imm = imm;
    @(negedge clk);
    issue_valid = 1'b0; issue_need = '0; issue_zero = 1'b0; issue_imm_ok = 1'b0; issue_imm = '0;
    for (int i = 0; i < 6; i++) exp_op[i] = 64'd0;
    if (im) exp_op[1] = imm;
  endtask

  // Grant one slot with data (wider values get truncated to slot width).
  task automatic grant(input int i, input logic [63:0] d);
    rd_grant = 6'd1 << i;
    rd_data0 = d; rd_data1 = d; rd_data2 = d[31:0];
    rd_data3 = d[3:0]; rd_data4 = d[3:0]; rd_data5 = d[3:0];
    @(negedge clk);
    rd_grant = '0;
  endtask

  task automatic t_reset;
    chk("R1 reset issue_ready", issue_ready, 1);
    chk("R2 reset rd_req", rd_req, 0);
    chk("R7 reset out_valid", out_valid, 0);
    for (int i = 0; i < 6; i++) exp_op[i] = 0;
    chk_ops("R9 reset operands");
  endtask

  task automatic t_all_fetch;
    logic [63:0] dv [6];
    out_ready = 1'b1;
    issue(6'b111111, 0, 0, 0);
    chk("R2 all requested", rd_req, 6'b111111);
    chk("R1 busy after issue", issue_ready, 0);
    dv[0] = 64'h1111_2222_3333_4444; dv[1] = 64'hAAAA_BBBB_CCCC_DDDD;
    dv[2] = 64'hFFFF_FFFF_1234_5678; dv[3] = 64'h7; dv[4] = 64'hFFFF_FFFF_FFFF_FFF9; dv[5] = 64'hC;
    foreach (dv[k]) ;
    for (int s = 5; s >= 0; s--) begin
      chk("R7 not early", out_valid, 0);
      grant(s, dv[s]);
      chk("R6 req drops after grant", rd_req[s], 0);
      exp_op[s] = dv[s] & wmask(s);
    end
    chk("R7 valid after last grant", out_valid, 1);
    chk_ops("R9 fetched widths");
    @(negedge clk);
    chk("R8 done after accept", out_valid, 0);
    chk("R8 idle after accept", issue_ready, 1);
  endtask

  task automatic t_zero;
    issue(6'b000111, 1, 0, 0);
    chk("R3 R5 no req slot0", rd_req, 6'b000110);
    grant(1, 64'h55);
    exp_op[1] = 64'h55;
    chk("R6 held slot2", rd_req, 6'b000100);
    @(negedge clk);
    chk("R6 still held slot2", rd_req, 6'b000100);
    grant(2, 64'h9876);
    exp_op[2] = 64'h9876;
    chk("R7 valid zero case", out_valid, 1);
    chk_ops("R3 zero operand");
    @(negedge clk);
  endtask

  task automatic t_imm;
    issue(6'b001011, 0, 1, 64'hDEAD_BEEF_0000_0001);
    chk("R4 R5 no req slot1", rd_req, 6'b001001);
    grant(0, 64'h0102);
    exp_op[0] = 64'h0102;
    grant(3, 64'h5);
    exp_op[3] = 64'h5;
    chk("R7 valid imm case", out_valid, 1);
    chk_ops("R4 immediate operand");
    @(negedge clk);
  endtask

  task automatic t_none;
    issue(6'b000011, 1, 1, 64'h42);
    chk("R7 immediate valid no reads", out_valid, 1);
    chk("R2 no requests", rd_req, 0);
    chk_ops("R3 R4 both overrides");
    @(negedge clk);
  endtask

  task automatic t_stall_and_busy;
    out_ready = 1'b0;
    issue(6'b000100, 0, 0, 0);
    // issue attempt while busy: must be ignored
    issue_valid = 1'b1; issue_need = 6'b111111; issue_imm_ok = 1'b1; issue_imm = 64'h77;
    @(negedge clk);
    issue_valid = 1'b0; issue_need = '0; issue_imm_ok = 1'b0; issue_imm = '0;
    chk("R1 busy issue ignored req", rd_req, 6'b000100);
    chk("R1 busy issue ignored op1", out_op1, 0);
    // grant on non-pending slot
    grant(4, 64'hA);
    chk("R10 spurious grant ignored", out_op4, 0);
    chk("R10 req unchanged", rd_req, 6'b000100);
    grant(2, 64'h3C);
    exp_op[2] = 64'h3C;
    for (int c = 0; c < 3; c++) begin
      chk("R8 valid held under stall", out_valid, 1);
      chk_ops("R8 operands held");
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8 released", out_valid, 0);
    chk("R8 R1 idle again", issue_ready, 1);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_all_fetch();
    t_zero();
    t_imm();
    t_none();
    t_stall_and_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule